// File: doc/BRIEF.md
# Variable-Length Instruction Operand Parser

This block sits behind an instruction byte fetcher and breaks a continuous byte stream into instructions. It first decodes an opcode of one or two bytes. A small table keyed by that opcode gives the number of operand specifiers that follow and the data size of each operand. The block then walks each specifier in turn. It reads the mode byte, consumes whatever extra bytes that mode calls for, and emits one operand record. The record carries the addressing mode, the register number and a 32-bit value, which is either a literal, a sign-extended displacement or an immediate.

Bytes arrive on a valid/ready stream and records leave on a valid/ready stream. While a record waits to be taken, the parser stops accepting bytes. An indexed specifier is followed by a base specifier, and the parser folds the two into one record for the same operand slot. An unknown opcode, or a base specifier that is not allowed, produces a one-cycle error pulse. After either error the parser treats the next byte as an opcode. Operand evaluation, memory access and execution belong to later stages.

Top module: `vlx_opnd_parser`

## Requirements
- R1: While `rst_n` is low on a rising edge, after that edge `rec_valid` and `err` are 0 and `in_ready` is 1.
- R2: The opcode table is as follows, with operand sizes listed from the first operand onward (B = 1 byte, W = 2, L = 4): 0x10 is two operands B,B; 0x20 is W,W; 0x30 is L,L,L; 0x40 is one operand L; 0x50 is B,W,L. The two-byte opcode is the escape byte 0xFD followed by 0x31, and it has two operands W,L.
- R3: Each operand slot produces exactly one record. `rec_last` is 1 only on the record of the final operand, and the byte that follows that operand is decoded as a new opcode.
- R4: A mode byte whose upper nibble is 0 to 3 is a short literal. It takes no extra bytes, and its record has `rec_mode` equal to that nibble, `rec_reg` = 0 and `rec_value` equal to mode byte bits [5:0], zero-extended.
- R5: Upper nibble 5, 6 or 7, or upper nibble 8 or 9 with a register other than 15, takes no extra bytes. Its record has `rec_value` = 0 and `rec_reg` set to the lower nibble.
- R6: Upper nibble 0xA or 0xB takes 1 extra byte, 0xC or 0xD takes 2, and 0xE or 0xF takes 4. The extra bytes are taken as a displacement, least significant byte first, and sign-extended to 32 bits.
- R7: Upper nibble 8 with register 15 is an immediate of the operand's table size, assembled least significant byte first and sign-extended. Upper nibble 9 with register 15 is a 4-byte absolute address.
- R8: Upper nibble 4 marks an index. The next specifier is the base, in the same slot. The single record carries `rec_indexed` = 1, `rec_index_reg` equal to the index byte's lower nibble, and the base's mode, register and value.
- R9: A base specifier with upper nibble 0 to 5 raises `err` and returns the parser to opcode fetch.
- R10: An opcode byte not listed in R2, or an escape byte followed by anything other than 0x31, raises `err` for one cycle. The next byte is treated as an opcode.
- R11: While `rec_valid` is 1 and `rec_ready` is 0, the record holds its value, `in_ready` is 0 and no byte is consumed.
- R12: A record appears in the cycle after the byte that completes its specifier is accepted. The error pulse appears in the cycle after the offending byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| rec_valid | output | 1 | Operand record valid |
| rec_ready | input | 1 | Consumer takes the record |
| rec_mode | output | 4 | Mode class (upper nibble of the mode byte) |
| rec_reg | output | 4 | Register number |
| rec_value | output | 32 | Literal, displacement or immediate value |
| rec_indexed | output | 1 | Operand carried an index prefix |
| rec_index_reg | output | 4 | Index register |
| rec_last | output | 1 | Final operand of the instruction |
| err | output | 1 | Reserved opcode or illegal base, one-cycle pulse |

## Verification
A record and an error pulse are each due one clock after the byte that completes them is accepted. `in_ready` follows `rec_valid` and `rec_ready` within the same cycle. Inputs change just after each rising edge, and the bench compares all outputs at the falling edge, against a behavioural model. That model re-parses the bytes of the current instruction from its start each time a byte is accepted. A record or error the model produces at one falling edge is therefore the one due at the next falling edge. Random gaps in `in_valid` and random or long stalls on `rec_ready` keep the due cycle moving against the byte order.

// File: rtl/vlx_pkg.sv
// Shared constants, types and helpers for the operand parser.
// Assumes 32-bit operand values and at most three operands per instruction.
package vlx_pkg;
    localparam int VAL_W     = 32;
    localparam int VAL_BYTES = VAL_W / 8;
    localparam int LANE_W    = $clog2(VAL_BYTES);
    localparam int LEN_W     = $clog2(VAL_BYTES + 1);
    localparam int MAX_OPS   = 3;
    localparam int CNT_W     = $clog2(MAX_OPS + 1);
    localparam logic [7:0] OPC_ESCAPE = 8'hFD;

    // operand data size codes
    localparam logic [1:0] DSZ_BYTE = 2'd0;
    localparam logic [1:0] DSZ_WORD = 2'd1;
    localparam logic [1:0] DSZ_LONG = 2'd2;

    typedef enum logic [1:0] {PS_OPC, PS_OPC2, PS_MODE, PS_EXT} pstate_e;

    typedef struct packed {
        logic                   known;
        logic                   escape;
        logic [CNT_W-1:0]       n_ops;
        logic [2*MAX_OPS-1:0]   sizes;   // two bits per operand, operand 0 lowest
    } opinfo_t;

    // build a table entry
    function automatic opinfo_t mk_entry(input logic [CNT_W-1:0] n,
                                         input logic [2*MAX_OPS-1:0] s);
        opinfo_t e;
        e.known  = 1'b1;
        e.escape = 1'b0;
        e.n_ops  = n;
        e.sizes  = s;
        return e;
    endfunction

    // byte length of a data size code
    function automatic logic [LEN_W-1:0] dsize_bytes(input logic [1:0] d);
        case (d)
            DSZ_BYTE: return LEN_W'(1);
            DSZ_WORD: return LEN_W'(2);
            default:  return LEN_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/vlx_optab.sv
// Opcode lookup: operand count and per-operand data size.
// Assumes 'second' marks the byte that follows the escape byte.
module vlx_optab
    import vlx_pkg::*;
(
    input  logic [7:0] op_byte,
    input  logic       second,
    output opinfo_t    info
);
    // decode one opcode byte against the table
    always_comb begin
        info = '0;
        if (!second) begin
            case (op_byte)
                8'h10:      info = mk_entry(CNT_W'(2), {DSZ_BYTE, DSZ_BYTE, DSZ_BYTE});
                8'h20:      info = mk_entry(CNT_W'(2), {DSZ_BYTE, DSZ_WORD, DSZ_WORD});
                8'h30:      info = mk_entry(CNT_W'(3), {DSZ_LONG, DSZ_LONG, DSZ_LONG});
                8'h40:      info = mk_entry(CNT_W'(1), {DSZ_BYTE, DSZ_BYTE, DSZ_LONG});
                8'h50:      info = mk_entry(CNT_W'(3), {DSZ_LONG, DSZ_WORD, DSZ_BYTE});
                OPC_ESCAPE: info.escape = 1'b1;
                default:    info = '0;
            endcase
        end else begin
            case (op_byte)
                8'h31:   info = mk_entry(CNT_W'(2), {DSZ_BYTE, DSZ_LONG, DSZ_WORD});
                default: info = '0;
            endcase
        end
    end
endmodule

// File: rtl/vlx_spec_dec.sv
// Mode byte decoder: class, register, count of extra bytes, and flags.
// Assumes op_size is the table size of the operand being parsed.
module vlx_spec_dec
    import vlx_pkg::*;
(
    input  logic [7:0]       mode_byte,
    input  logic [1:0]       op_size,
    input  logic             base_phase,
    output logic [3:0]       cls,
    output logic [3:0]       rnum,
    output logic [LEN_W-1:0] ext_len,
    output logic             is_lit,
    output logic             is_idx,
    output logic             bad_base
);
    // split the nibbles and flag the special classes
    always_comb begin
        cls      = mode_byte[7:4];
        rnum     = mode_byte[3:0];
        is_lit   = (mode_byte[7:6] == 2'b00);
        is_idx   = (mode_byte[7:4] == 4'h4);
        bad_base = base_phase && (mode_byte[7:4] <= 4'h5);
    end

    // number of parameter bytes that follow the mode byte
    always_comb begin
        case (mode_byte[7:4])
            4'h8:        ext_len = (mode_byte[3:0] == 4'hF) ? dsize_bytes(op_size) : '0;
            4'h9:        ext_len = (mode_byte[3:0] == 4'hF) ? LEN_W'(4) : '0;
            4'hA, 4'hB:  ext_len = LEN_W'(1);
            4'hC, 4'hD:  ext_len = LEN_W'(2);
            4'hE, 4'hF:  ext_len = LEN_W'(4);
            default:     ext_len = '0;
        endcase
    end
endmodule

// File: rtl/vlx_assemble.sv
// Little-endian byte collector with sign extension by length.
// Assumes clr and load are never both high; lanes fill from 0 upward.
module vlx_assemble
    import vlx_pkg::*;
#(
    parameter int NB = VAL_BYTES,
    localparam int LW = $clog2(NB),
    localparam int NW = $clog2(NB + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [LW-1:0]   lane,
    input  logic [7:0]      in_byte,
    input  logic [NW-1:0]   len,
    output logic [8*NB-1:0] value
);
    logic [8*NB-1:0] acc;
    logic [8*NB-1:0] merged;

    // place the incoming byte into its lane
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign merged[8*g +: 8] = (load && lane == LW'(g)) ? in_byte : acc[8*g +: 8];
    end

    // keep the bytes seen so far
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (load) acc <= merged;
    end

    // replicate the top bit of the last lane above it
    always_comb begin
        value = merged;
        for (int k = 1; k < NB; k++) begin
            if (int'(len) == k) begin
                for (int j = k; j < NB; j++) value[8*j +: 8] = {8{merged[8*k-1]}};
            end
        end
    end
endmodule

// File: rtl/vlx_opnd_parser.sv
// Operand specifier parser: opcode, then one record per operand slot.
// Assumes one byte per cycle at most; stalls input while a record waits.
module vlx_opnd_parser
    import vlx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [3:0]       rec_mode,
    output logic [3:0]       rec_reg,
    output logic [VAL_W-1:0] rec_value,
    output logic             rec_indexed,
    output logic [3:0]       rec_index_reg,
    output logic             rec_last,
    output logic             err
);
    pstate_e              st;
    logic [CNT_W-1:0]     n_ops_q, opnd_q;
    logic [2*MAX_OPS-1:0] sizes_q;
    logic                 idx_pend_q;
    logic [3:0]           idx_reg_q, cls_q, reg_q;
    logic [LEN_W-1:0]     len_q;
    logic [LANE_W-1:0]    lane_q;

    logic                 rec_valid_q, rec_last_q, rec_indexed_q, err_q;
    logic [3:0]           rec_mode_q, rec_reg_q, rec_index_reg_q;
    logic [VAL_W-1:0]     rec_value_q;

    opinfo_t              op_info;
    logic [3:0]           cls, rnum;
    logic [LEN_W-1:0]     ext_len;
    logic                 is_lit, is_idx, bad_base;
    logic [VAL_W-1:0]     asm_value;

    logic                 fire, last_lane, final_opnd, emit_now;
    logic [3:0]           emit_mode, emit_reg;
    logic [VAL_W-1:0]     emit_value;

    assign in_ready = !rec_valid_q || rec_ready;
    assign fire     = in_valid && in_ready;

    vlx_optab u_optab (
        .op_byte (in_data),
        .second  (st == PS_OPC2),
        .info    (op_info)
    );

    vlx_spec_dec u_dec (
        .mode_byte  (in_data),
        .op_size    (sizes_q[2*opnd_q +: 2]),
        .base_phase (idx_pend_q),
        .cls        (cls),
        .rnum       (rnum),
        .ext_len    (ext_len),
        .is_lit     (is_lit),
        .is_idx     (is_idx),
        .bad_base   (bad_base)
    );

    vlx_assemble #(.NB(VAL_BYTES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fire && st == PS_MODE),
        .load    (fire && st == PS_EXT),
        .lane    (lane_q),
        .in_byte (in_data),
        .len     (len_q),
        .value   (asm_value)
    );

    // decide whether this byte closes a specifier and what it reports
    always_comb begin
        last_lane  = (LEN_W'(lane_q) == len_q - LEN_W'(1));
        final_opnd = (opnd_q == n_ops_q - CNT_W'(1));
        emit_now   = fire && (((st == PS_MODE) && !bad_base && !is_idx && ext_len == '0) ||
                              ((st == PS_EXT) && last_lane));
        if (st == PS_MODE) begin
            emit_mode  = cls;
            emit_reg   = is_lit ? 4'h0 : rnum;
            emit_value = is_lit ? {{(VAL_W-6){1'b0}}, in_data[5:0]} : '0;
        end else begin
            emit_mode  = cls_q;
            emit_reg   = reg_q;
            emit_value = asm_value;
        end
    end

    // parser sequencing and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st              <= PS_OPC;
            n_ops_q         <= '0;
            opnd_q          <= '0;
            sizes_q         <= '0;
            idx_pend_q      <= 1'b0;
            idx_reg_q       <= '0;
            cls_q           <= '0;
            reg_q           <= '0;
            len_q           <= '0;
            lane_q          <= '0;
            rec_valid_q     <= 1'b0;
            rec_last_q      <= 1'b0;
            rec_indexed_q   <= 1'b0;
            rec_mode_q      <= '0;
            rec_reg_q       <= '0;
            rec_index_reg_q <= '0;
            rec_value_q     <= '0;
            err_q           <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (rec_valid_q && rec_ready) rec_valid_q <= 1'b0;
            if (fire) begin
                case (st)
                    PS_OPC: begin
                        if (op_info.escape) begin
                            st <= PS_OPC2;
                        end else if (op_info.known) begin
                            n_ops_q    <= op_info.n_ops;
                            sizes_q    <= op_info.sizes;
                            opnd_q     <= '0;
                            idx_pend_q <= 1'b0;
                            st         <= PS_MODE;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                    PS_OPC2: begin
                        if (op_info.known) begin
                            n_ops_q    <= op_info.n_ops;
                            sizes_q    <= op_info.sizes;
                            opnd_q     <= '0;
                            idx_pend_q <= 1'b0;
                            st         <= PS_MODE;
                        end else begin
                            err_q <= 1'b1;
                            st    <= PS_OPC;
                        end
                    end
                    PS_MODE: begin
                        if (bad_base) begin
                            err_q      <= 1'b1;
                            idx_pend_q <= 1'b0;
                            st         <= PS_OPC;
                        end else if (is_idx) begin
                            idx_pend_q <= 1'b1;
                            idx_reg_q  <= rnum;
                        end else if (ext_len != '0) begin
                            cls_q  <= cls;
                            reg_q  <= rnum;
                            len_q  <= ext_len;
                            lane_q <= '0;
                            st     <= PS_EXT;
                        end
                    end
                    PS_EXT: begin
                        if (!last_lane) lane_q <= lane_q + LANE_W'(1);
                    end
                    default: st <= PS_OPC;
                endcase
            end
            if (emit_now) begin
                rec_valid_q     <= 1'b1;
                rec_mode_q      <= emit_mode;
                rec_reg_q       <= emit_reg;
                rec_value_q     <= emit_value;
                rec_indexed_q   <= idx_pend_q;
                rec_index_reg_q <= idx_pend_q ? idx_reg_q : 4'h0;
                rec_last_q      <= final_opnd;
                idx_pend_q      <= 1'b0;
                if (final_opnd) begin
                    st <= PS_OPC;
                end else begin
                    opnd_q <= opnd_q + CNT_W'(1);
                    st     <= PS_MODE;
                end
            end
        end
    end

    assign rec_valid     = rec_valid_q;
    assign rec_mode      = rec_mode_q;
    assign rec_reg       = rec_reg_q;
    assign rec_value     = rec_value_q;
    assign rec_indexed   = rec_indexed_q;
    assign rec_index_reg = rec_index_reg_q;
    assign rec_last      = rec_last_q;
    assign err           = err_q;
endmodule

// File: rtl/vlx_opnd_parser_chk.sv
// Property checker for the operand parser, attached by bind.
// Assumes the port names of vlx_opnd_parser.
module vlx_opnd_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  in_data,
    input logic        in_ready,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic [3:0]  rec_mode,
    input logic [3:0]  rec_reg,
    input logic [31:0] rec_value,
    input logic        rec_indexed,
    input logic [3:0]  rec_index_reg,
    input logic        rec_last,
    input logic        err
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rec_valid && !err));

    // R11
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_value) &&
                                       $stable(rec_mode) && $stable(rec_reg) &&
                                       $stable(rec_last)));

    // R4
    literal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_mode < 4'h4) |-> (rec_value[31:6] == '0 && rec_reg == 4'h0));

    // R5
    regmode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_mode >= 4'h5 && rec_mode <= 4'h7) |-> (rec_value == '0));

    // R6
    byte_disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (rec_mode == 4'hA || rec_mode == 4'hB)) |->
        (rec_value[31:7] == '0 || rec_value[31:7] == '1));

    // R8
    base_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_indexed) |-> (rec_mode >= 4'h6));
endmodule

bind vlx_opnd_parser vlx_opnd_parser_chk u_chk (.*);

// File: tb/vlx_opnd_parser_bench.sv
// Bench: behavioural re-parsing model, compared at every falling edge.
module vlx_opnd_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n, in_valid, rec_ready;
    logic [7:0]  in_data;
    logic        in_ready, rec_valid, rec_indexed, rec_last, err;
    logic [3:0]  rec_mode, rec_reg, rec_index_reg;
    logic [31:0] rec_value;

    always #5 clk = ~clk;

    vlx_opnd_parser u_vlx_opnd_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_mode(rec_mode), .rec_reg(rec_reg), .rec_value(rec_value),
        .rec_indexed(rec_indexed), .rec_index_reg(rec_index_reg),
        .rec_last(rec_last), .err(err)
    );

    int checks = 0, errors = 0;
    bit mon_on = 1'b0, done = 1'b0;
    byte unsigned stim[$];
    int cyc = 0;

    // table model
    bit op_ok; int op_n; int op_sz[3];
    task automatic lookup(input bit two, input int b);
        op_ok = 1; op_n = 0; op_sz = '{0, 0, 0};
        if (!two) begin
            case (b)
                'h10: begin op_n = 2; op_sz = '{1, 1, 0}; end
                'h20: begin op_n = 2; op_sz = '{2, 2, 0}; end
                'h30: begin op_n = 3; op_sz = '{4, 4, 4}; end
                'h40: begin op_n = 1; op_sz = '{4, 0, 0}; end
                'h50: begin op_n = 3; op_sz = '{1, 2, 4}; end
                default: op_ok = 0;
            endcase
        end else if (b == 'h31) begin op_n = 2; op_sz = '{2, 4, 0}; end
        else op_ok = 0;
    endtask

    // reference parser state
    byte unsigned cur[$];
    int emitted = 0;
    int ev_kind;  // 0 none, 1 record, 2 reserved opcode, 3 illegal base
    logic [3:0]  ev_mode, ev_reg, ev_ixr;
    logic [31:0] ev_val;
    bit ev_ix, ev_last;

    task automatic ref_feed(input byte unsigned b);
        int p, cls, r, len;
        logic [31:0] v;
        ev_kind = 0;
        cur.push_back(b);
        if (cur[0] == 8'hFD) begin
            if (cur.size() < 2) return;
            lookup(1, cur[1]); p = 2;
        end else begin
            lookup(0, cur[0]); p = 1;
        end
        if (!op_ok) begin ev_kind = 2; cur.delete(); emitted = 0; return; end
        for (int i = 0; i < op_n; i++) begin
            if (p >= cur.size()) return;
            cls = cur[p] >> 4; r = cur[p] & 15;
            ev_ix = 0; ev_ixr = 0;
            if (cls == 4) begin
                ev_ix = 1; ev_ixr = 4'(r); p++;
                if (p >= cur.size()) return;
                cls = cur[p] >> 4; r = cur[p] & 15;
                if (cls <= 5) begin ev_kind = 3; cur.delete(); emitted = 0; return; end
            end
            if (cls >= 14) len = 4;
            else if (cls >= 12) len = 2;
            else if (cls >= 10) len = 1;
            else if (cls == 8 && r == 15) len = op_sz[i];
            else if (cls == 9 && r == 15) len = 4;
            else len = 0;
            if (p + len >= cur.size()) return;
            if (i == emitted) begin
                v = 0;
                for (int k = 0; k < len; k++) v[8*k +: 8] = cur[p+1+k];
                if (len > 0 && len < 4 && v[8*len-1])
                    for (int j = len; j < 4; j++) v[8*j +: 8] = 8'hFF;
                ev_mode = 4'(cls);
                ev_reg  = (cls < 4) ? 4'h0 : 4'(r);
                ev_val  = (cls < 4) ? 32'(cur[p] & 63) : v;
                ev_last = (i == op_n - 1);
                ev_kind = 1;
                emitted++;
                if (ev_last) begin cur.delete(); emitted = 0; end
                return;
            end
            p += len + 1;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] m, input logic [3:0] r);
        if (m < 4) return "R4 literal";
        if (m >= 4'hA) return "R6 displacement";
        if ((m == 4'h8 || m == 4'h9) && r == 4'hF) return "R7 immediate/absolute";
        return "R5 register mode";
    endfunction

    // monitor: compare outputs, then advance the model by this cycle's handshakes
    bit shown = 0, exp_err = 0; int exp_err_kind = 0;
    logic [3:0] e_mode, e_reg, e_ixr; logic [31:0] e_val; bit e_ix, e_last;
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            chk(rec_valid === shown, "R12 record timing", 32'(rec_valid), 32'(shown));
            if (shown && rec_valid) begin
                chk(rec_mode === e_mode, tag_of(e_mode, e_reg), 32'(rec_mode), 32'(e_mode));
                chk(rec_reg === e_reg, tag_of(e_mode, e_reg), 32'(rec_reg), 32'(e_reg));
                chk(rec_value === e_val, tag_of(e_mode, e_reg), rec_value, e_val);
                chk(rec_indexed === e_ix, "R8 index flag", 32'(rec_indexed), 32'(e_ix));
                chk(rec_index_reg === e_ixr, "R8 index register", 32'(rec_index_reg), 32'(e_ixr));
                chk(rec_last === e_last, "R2/R3 last flag", 32'(rec_last), 32'(e_last));
            end
            chk(err === exp_err, (exp_err_kind == 3) ? "R9 illegal base" : "R10 reserved opcode",
                32'(err), 32'(exp_err));
            chk(in_ready === (!shown || rec_ready), "R11 input stall", 32'(in_ready),
                32'(!shown || rec_ready));
            if (shown && rec_ready) shown = 0;
            exp_err = 0; exp_err_kind = 0;
            if (in_valid && in_ready) begin
                ref_feed(in_data);
                if (ev_kind == 1) begin
                    shown = 1; e_mode = ev_mode; e_reg = ev_reg; e_val = ev_val;
                    e_ix = ev_ix; e_ixr = ev_ix ? ev_ixr : 4'h0; e_last = ev_last;
                end else if (ev_kind > 1) begin
                    exp_err = 1; exp_err_kind = ev_kind;
                end
            end
        end
    end

    // stimulus generation
    task automatic push_spec(input int i, input int cls);
        int r = $urandom % 16, len;
        if ((cls == 8 || cls == 9) && ($urandom % 2)) r = 15;
        stim.push_back(8'((cls << 4) | r));
        if (cls >= 14) len = 4; else if (cls >= 12) len = 2; else if (cls >= 10) len = 1;
        else if (cls == 8 && r == 15) len = op_sz[i];
        else if (cls == 9 && r == 15) len = 4; else len = 0;
        for (int k = 0; k < len; k++) stim.push_back(8'($urandom));
    endtask

    task automatic gen_instr();
        int sel = $urandom % 20, b, n;
        if (sel == 0) begin
            do b = $urandom % 256; while (b == 'h10 || b == 'h20 || b == 'h30 ||
                                          b == 'h40 || b == 'h50 || b == 'hFD);
            stim.push_back(8'(b)); return;
        end
        if (sel == 1) begin
            stim.push_back(8'hFD);
            do b = $urandom % 256; while (b == 'h31);
            stim.push_back(8'(b)); return;
        end
        case ($urandom % 6)
            0: b = 'h10; 1: b = 'h20; 2: b = 'h30; 3: b = 'h40; 4: b = 'h50; default: b = 'h131;
        endcase
        if (b == 'h131) begin stim.push_back(8'hFD); stim.push_back(8'h31); lookup(1, 'h31); end
        else begin stim.push_back(8'(b)); lookup(0, b); end
        n = op_n;
        for (int i = 0; i < n; i++) begin
            int c = $urandom % 16;
            if ($urandom % 25 == 0) begin
                stim.push_back(8'h40 | 8'($urandom % 16));
                stim.push_back(8'(($urandom % 6) << 4) | 8'($urandom % 16));
                return;
            end
            if (c == 4) begin
                stim.push_back(8'h40 | 8'($urandom % 16));
                push_spec(i, 6 + $urandom % 10);
            end else push_spec(i, c);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ready pattern for the record stream, with one long stall window
    initial begin
        rec_ready = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (cyc > 300 && cyc < 360) rec_ready = 1'b0;
            else rec_ready = ($urandom % 10) < 7;
        end
    end

    // reset, directed bytes, random instructions, byte driver
    initial begin
        byte unsigned dir[$] = '{
            8'h10, 8'h05, 8'h51,
            8'h20, 8'h8F, 8'h34, 8'h82, 8'hC3, 8'h00, 8'h80,
            8'h30, 8'h42, 8'hAE, 8'hFF, 8'h9F, 8'h78, 8'h56, 8'h34, 8'h12,
            8'hEF, 8'h01, 8'h00, 8'h00, 8'h80,
            8'h77,
            8'hFD, 8'h31, 8'h3F, 8'h8F, 8'h44, 8'h33, 8'h22, 8'h11,
            8'hFD, 8'h99, 8'h40, 8'h45, 8'h53, 8'h40, 8'h65,
            8'h50, 8'h8F, 8'h80, 8'h8F, 8'h01, 8'h02, 8'h8F, 8'h01, 8'h02, 8'h03, 8'h04,
            8'h40, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h7D
        };
        int i;
        bit take;
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(rec_valid === 1'b0, "R1 rec_valid in reset", 32'(rec_valid), 0);
        chk(err === 1'b0, "R1 err in reset", 32'(err), 0);
        chk(in_ready === 1'b1, "R1 in_ready in reset", 32'(in_ready), 1);
        foreach (dir[k]) stim.push_back(dir[k]);
        for (int n = 0; n < 300; n++) gen_instr();
        @(posedge clk); #2;
        rst_n = 1'b1; mon_on = 1'b1;
        i = 0;
        while (i < stim.size()) begin
            in_valid = ($urandom % 8) != 0;
            in_data  = stim[i];
            @(negedge clk);
            take = in_valid && in_ready;
            @(posedge clk); #2;
            if (take) i++;
        end
        in_valid = 1'b0;
        repeat (20) @(posedge clk);
        finish_run();
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end
endmodule